// File: doc/BRIEF.md
# Control Register Execution Unit

This block holds the processor's 32-bit status/control word and its 4-bit interrupt-enable mask. Instruction decode happens upstream. It hands this unit one control operation per `op_valid` strobe, together with the accumulator byte, an 8-bit immediate and the 32-bit register-pair value. The unit then updates its state on that clock edge.

The operations are as follows:
- Whole-word loads of the status word.
- Byte-group reads and writes.
- Set and clear of the bus-lock and long-word bits.
- Masked interrupt enable and disable.
- Two test operations that copy chosen status bits into the S, Z, V and C condition flags.

Read results appear on registered outputs: the pair-read word and the accumulator-read byte. Each read output keeps its value until the next read operation of its kind.

Top module: `ctl_reg_unit`

## Requirements
- R1: After reset, the following are all zero: the status word, the interrupt mask, the flags, `pair_rd` and `acc_rd`. This means `long_word`=0 and `bus_lock`=0.
- R2: Op 1 (source `acc_in`) and op 2 (source `imm_in`) write the source byte into status bits 31:24, 23:16 and 15:8 at once. Bits 7:0 are kept.
- R3: Op 3 with status bit 6 clear does three things. Pair bits 15:8 go into status bits 31:24, 23:16 and 15:8. Pair bit 0 goes into status bit 0. Status bits 7:1 are kept.
- R4: Op 3 with status bit 6 set does three things. Pair bits 31:16 go into status bits 31:16. Pair bits 15:8 go into status bits 15:8 and pair bit 0 into status bit 0. Status bits 7:1 are kept.
- R5: Op 4 loads `pair_rd` with the status word. When bit 6 is set, all 32 bits are loaded. Otherwise bits 15:0 are loaded, zero-extended. The value shows after the edge.
- R6: `grp_sel` picks a status byte: 0 is bits 7:0, 1 is 15:8, 2 is 23:16 and 3 is 31:24. Op 5 copies the chosen byte to `acc_rd`. Op 6 writes `acc_in` into it, and op 7 writes `imm_in` into it.
- R7: Op 8 sets status bit 1 and op 9 clears it. Op 10 sets status bit 6 and op 11 clears it. `bus_lock` shows bit 1 and `long_word` shows bit 6.
- R8: Op 12 clears each interrupt-mask bit i where `imm_in[i]`=1. Op 13 sets each such bit. Both ops also drive status bit 5 to the same value (0 for op 12, 1 for op 13), but only when `imm_in[0]`=1. `int_en` shows the mask.
- R9: Op 14 loads the flags from status bits: S from bit 16, Z from bit 24, V from bit 0 and C from bit 8. `flags` is ordered {S,Z,V,C} from bit 3 down to bit 0.
- R10: Op 15 loads S from status bit 7, Z from bit 6 and C from bit 1. V keeps its previous value.
- R11: With `op_valid` low, or with op 0, no state or output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Executes `op_sel` on this edge |
| op_sel | input | 4 | Operation code |
| grp_sel | input | 2 | Status byte selector for byte-group ops |
| acc_in | input | 8 | Accumulator value |
| imm_in | input | 8 | Immediate value; bits 3:0 are the interrupt mask operand |
| pair_in | input | 32 | Register-pair value |
| pair_rd | output | 32 | Last status-word read |
| acc_rd | output | 8 | Last byte-group read |
| flags | output | 4 | {S,Z,V,C} condition flags |
| int_en | output | 4 | Interrupt-enable mask |
| long_word | output | 1 | Long-word mode (status bit 6) |
| bus_lock | output | 1 | Bus-lock request (status bit 1) |

## Verification
A corrupted status byte is invisible until something reads it. It shows one cycle after the next op 4, op 5 or test op, so every write in the bench is followed by a read or a test. A wrong bit 1 or bit 6 shows on `bus_lock` or `long_word` right after the edge. Mode-dependent faults only show on the next op 3 or op 4, which changes the zero-extension of `pair_rd`. A lost V bit only shows after a mode test, which is why one follows a bank test that set V.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
    localparam int SR_W     = 32;
    localparam int BYTE_W   = 8;
    localparam int PAIR_W   = 32;
    localparam int HALF_W   = PAIR_W / 2;
    localparam int IER_W    = 4;
    localparam int NBYTES   = SR_W / BYTE_W;
    localparam int GRP_W    = $clog2(NBYTES);
    localparam int OP_W     = 4;

    localparam int BIT_LOCK = 1;
    localparam int BIT_IEN  = 5;
    localparam int BIT_LW   = 6;
    localparam int BIT_MODE_S = 7;

    typedef enum logic [OP_W-1:0] {
        OP_NOP       = 4'd0,
        OP_SR_ACC    = 4'd1,
        OP_SR_IMM    = 4'd2,
        OP_SR_PAIR   = 4'd3,
        OP_PAIR_SR   = 4'd4,
        OP_ACC_GRP   = 4'd5,
        OP_GRP_ACC   = 4'd6,
        OP_GRP_IMM   = 4'd7,
        OP_LOCK_SET  = 4'd8,
        OP_LOCK_CLR  = 4'd9,
        OP_LW_SET    = 4'd10,
        OP_LW_CLR    = 4'd11,
        OP_IEN_CLR   = 4'd12,
        OP_IEN_SET   = 4'd13,
        OP_TEST_BANK = 4'd14,
        OP_TEST_MODE = 4'd15
    } ctl_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic v;
        logic c;
    } ctl_flags_t;

    typedef struct packed {
        logic [SR_W-1:0]   sr;
        logic [IER_W-1:0]  ier;
        ctl_flags_t        flags;
        logic [PAIR_W-1:0] pair_rd;
        logic [BYTE_W-1:0] acc_rd;
    } ctl_state_t;
endpackage

// File: rtl/ctl_sr_next.sv
module ctl_sr_next
    import ctl_pkg::*;
(
    input  ctl_op_e           op,
    input  logic [GRP_W-1:0]  grp,
    input  logic [BYTE_W-1:0] acc,
    input  logic [BYTE_W-1:0] imm,
    input  logic [PAIR_W-1:0] pair,
    input  logic [SR_W-1:0]   sr_q,
    output logic [SR_W-1:0]   sr_d
);
    logic [BYTE_W-1:0] bcast_byte;
    logic [BYTE_W-1:0] grp_byte;
    logic [SR_W-1:0]   bcast_word;
    logic [SR_W-1:0]   grp_word;
    logic [SR_W-1:0]   pair_word;
    logic [NBYTES-1:0] grp_hit;

    assign bcast_byte = (op == OP_SR_IMM) ? imm : acc;
    assign grp_byte   = (op == OP_GRP_IMM) ? imm : acc;

    // Per-lane selection: lane 0 is kept by broadcast, grp_sel hits one lane.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign grp_hit[b] = (grp == GRP_W'(b));
        assign grp_word[b*BYTE_W +: BYTE_W] =
            grp_hit[b] ? grp_byte : sr_q[b*BYTE_W +: BYTE_W];
        if (b == 0) begin : g_keep
            assign bcast_word[BYTE_W-1:0] = sr_q[BYTE_W-1:0];
        end else begin : g_bc
            assign bcast_word[b*BYTE_W +: BYTE_W] = bcast_byte;
        end
    end

    // Word load from the register pair, width chosen by the long-word bit.
    always_comb begin
        pair_word = sr_q;
        pair_word[HALF_W-1:BYTE_W] = pair[HALF_W-1:BYTE_W];
        pair_word[0]               = pair[0];
        if (sr_q[BIT_LW]) begin
            pair_word[SR_W-1:HALF_W] = pair[PAIR_W-1:HALF_W];
        end else begin
            pair_word[SR_W-1:SR_W-BYTE_W]        = pair[HALF_W-1:BYTE_W];
            pair_word[SR_W-BYTE_W-1:HALF_W]      = pair[HALF_W-1:BYTE_W];
        end
    end

    always_comb begin
        sr_d = sr_q;
        case (op)
            OP_SR_ACC, OP_SR_IMM: sr_d = bcast_word;
            OP_SR_PAIR:           sr_d = pair_word;
            OP_GRP_ACC, OP_GRP_IMM: sr_d = grp_word;
            OP_LOCK_SET:          sr_d[BIT_LOCK] = 1'b1;
            OP_LOCK_CLR:          sr_d[BIT_LOCK] = 1'b0;
            OP_LW_SET:            sr_d[BIT_LW]   = 1'b1;
            OP_LW_CLR:            sr_d[BIT_LW]   = 1'b0;
            OP_IEN_CLR:           if (imm[0]) sr_d[BIT_IEN] = 1'b0;
            OP_IEN_SET:           if (imm[0]) sr_d[BIT_IEN] = 1'b1;
            default:              sr_d = sr_q;
        endcase
    end
endmodule

// File: rtl/ctl_ier_next.sv
module ctl_ier_next
    import ctl_pkg::*;
(
    input  ctl_op_e          op,
    input  logic [IER_W-1:0] mask,
    input  logic [IER_W-1:0] ier_q,
    output logic [IER_W-1:0] ier_d
);
    always_comb begin
        case (op)
            OP_IEN_CLR: ier_d = ier_q & ~mask;
            OP_IEN_SET: ier_d = ier_q | mask;
            default:    ier_d = ier_q;
        endcase
    end
endmodule

// File: rtl/ctl_flag_test.sv
module ctl_flag_test
    import ctl_pkg::*;
(
    input  ctl_op_e         op,
    input  logic [SR_W-1:0] sr_q,
    input  ctl_flags_t      flags_q,
    output ctl_flags_t      flags_d
);
    localparam int BANK_S = 2 * BYTE_W;
    localparam int BANK_Z = 3 * BYTE_W;
    localparam int BANK_C = BYTE_W;

    always_comb begin
        flags_d = flags_q;
        case (op)
            OP_TEST_BANK: begin
                flags_d.s = sr_q[BANK_S];
                flags_d.z = sr_q[BANK_Z];
                flags_d.v = sr_q[0];
                flags_d.c = sr_q[BANK_C];
            end
            OP_TEST_MODE: begin
                flags_d.s = sr_q[BIT_MODE_S];
                flags_d.z = sr_q[BIT_LW];
                flags_d.c = sr_q[BIT_LOCK];
            end
            default: flags_d = flags_q;
        endcase
    end
endmodule

// File: rtl/ctl_reg_unit.sv
module ctl_reg_unit
    import ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [GRP_W-1:0]  grp_sel,
    input  logic [BYTE_W-1:0] acc_in,
    input  logic [BYTE_W-1:0] imm_in,
    input  logic [PAIR_W-1:0] pair_in,
    output logic [PAIR_W-1:0] pair_rd,
    output logic [BYTE_W-1:0] acc_rd,
    output logic [3:0]        flags,
    output logic [IER_W-1:0]  int_en,
    output logic              long_word,
    output logic              bus_lock
);
    ctl_op_e     op;
    ctl_state_t  st_q, st_d;
    logic [SR_W-1:0]   sr_nx;
    logic [IER_W-1:0]  ier_nx;
    ctl_flags_t        flags_nx;
    logic [PAIR_W-1:0] rd_word;
    logic [BYTE_W-1:0] rd_byte;

    assign op = ctl_op_e'(op_sel);

    ctl_sr_next u_sr (
        .op   (op),
        .grp  (grp_sel),
        .acc  (acc_in),
        .imm  (imm_in),
        .pair (pair_in),
        .sr_q (st_q.sr),
        .sr_d (sr_nx)
    );

    ctl_ier_next u_ier (
        .op    (op),
        .mask  (imm_in[IER_W-1:0]),
        .ier_q (st_q.ier),
        .ier_d (ier_nx)
    );

    ctl_flag_test u_flg (
        .op      (op),
        .sr_q    (st_q.sr),
        .flags_q (st_q.flags),
        .flags_d (flags_nx)
    );

    assign rd_word = st_q.sr[BIT_LW] ? st_q.sr
                                     : {{(PAIR_W-HALF_W){1'b0}}, st_q.sr[HALF_W-1:0]};
    assign rd_byte = st_q.sr[grp_sel*BYTE_W +: BYTE_W];

    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            st_d.sr    = sr_nx;
            st_d.ier   = ier_nx;
            st_d.flags = flags_nx;
            if (op == OP_PAIR_SR) st_d.pair_rd = rd_word;
            if (op == OP_ACC_GRP) st_d.acc_rd  = rd_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pair_rd   = st_q.pair_rd;
    assign acc_rd    = st_q.acc_rd;
    assign flags     = st_q.flags;
    assign int_en    = st_q.ier;
    assign long_word = st_q.sr[BIT_LW];
    assign bus_lock  = st_q.sr[BIT_LOCK];

    assert_bcast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_SR_ACC) |=>
            (st_q.sr[31:24] == $past(acc_in) && st_q.sr[15:8] == $past(acc_in)
             && st_q.sr[7:0] == $past(st_q.sr[7:0])));

    assert_pair_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_SR_PAIR && !long_word) |=>
            (st_q.sr[31:24] == $past(pair_in[15:8]) && st_q.sr[23:16] == $past(pair_in[15:8])));

    assert_read_long_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_PAIR_SR && long_word) |=> (pair_rd == $past(st_q.sr)));

    assert_lock_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_LOCK_SET) |=> bus_lock);

    assert_ien_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_IEN_CLR) |=> ((int_en & $past(imm_in[3:0])) == 4'b0));

    assert_mode_keeps_v_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_TEST_MODE) |=> (flags[1] == $past(flags[1])));

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid) |=> $stable(st_q));
endmodule

// File: tb/sim_ctl_reg_unit.sv
`timescale 1ns/1ps
module sim_ctl_reg_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [1:0]  grp_sel = '0;
    logic [7:0]  acc_in = '0;
    logic [7:0]  imm_in = '0;
    logic [31:0] pair_in = '0;
    logic [31:0] pair_rd;
    logic [7:0]  acc_rd;
    logic [3:0]  flags;
    logic [3:0]  int_en;
    logic        long_word;
    logic        bus_lock;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ctl_reg_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .grp_sel(grp_sel), .acc_in(acc_in), .imm_in(imm_in), .pair_in(pair_in),
        .pair_rd(pair_rd), .acc_rd(acc_rd), .flags(flags), .int_en(int_en),
        .long_word(long_word), .bus_lock(bus_lock)
    );

    // op grp acc imm pair | pair_rd acc_rd flags int_en lw lock | req
    localparam int NV = 29;
    localparam logic [107:0] VEC [NV] = '{
        {4'd1, 2'd0,8'hA5,8'h00,32'h0,        32'h00000000,8'h00,4'h0,4'h0,1'b0,1'b0,4'd2},  // R2
        {4'd4, 2'd0,8'h00,8'h00,32'h0,        32'h0000A500,8'h00,4'h0,4'h0,1'b0,1'b0,4'd5},  // R5
        {4'd14,2'd0,8'h00,8'h00,32'h0,        32'h0000A500,8'h00,4'hD,4'h0,1'b0,1'b0,4'd9},  // R9
        {4'd2, 2'd0,8'h00,8'h5A,32'h0,        32'h0000A500,8'h00,4'hD,4'h0,1'b0,1'b0,4'd2},  // R2
        {4'd14,2'd0,8'h00,8'h00,32'h0,        32'h0000A500,8'h00,4'h0,4'h0,1'b0,1'b0,4'd9},  // R9
        {4'd3, 2'd0,8'h00,8'h00,32'h12348101, 32'h0000A500,8'h00,4'h0,4'h0,1'b0,1'b0,4'd3},  // R3
        {4'd4, 2'd0,8'h00,8'h00,32'h0,        32'h00008101,8'h00,4'h0,4'h0,1'b0,1'b0,4'd3},  // R3
        {4'd14,2'd0,8'h00,8'h00,32'h0,        32'h00008101,8'h00,4'hF,4'h0,1'b0,1'b0,4'd9},  // R9
        {4'd10,2'd0,8'h00,8'h00,32'h0,        32'h00008101,8'h00,4'hF,4'h0,1'b1,1'b0,4'd7},  // R7
        {4'd4, 2'd0,8'h00,8'h00,32'h0,        32'h81818141,8'h00,4'hF,4'h0,1'b1,1'b0,4'd5},  // R5
        {4'd3, 2'd0,8'h00,8'h00,32'hDEAD33FE, 32'h81818141,8'h00,4'hF,4'h0,1'b1,1'b0,4'd4},  // R4
        {4'd4, 2'd0,8'h00,8'h00,32'h0,        32'hDEAD3340,8'h00,4'hF,4'h0,1'b1,1'b0,4'd4},  // R4
        {4'd8, 2'd0,8'h00,8'h00,32'h0,        32'hDEAD3340,8'h00,4'hF,4'h0,1'b1,1'b1,4'd7},  // R7
        {4'd15,2'd0,8'h00,8'h00,32'h0,        32'hDEAD3340,8'h00,4'h7,4'h0,1'b1,1'b1,4'd10}, // R10
        {4'd5, 2'd3,8'h00,8'h00,32'h0,        32'hDEAD3340,8'hDE,4'h7,4'h0,1'b1,1'b1,4'd6},  // R6
        {4'd6, 2'd2,8'h77,8'h00,32'h0,        32'hDEAD3340,8'hDE,4'h7,4'h0,1'b1,1'b1,4'd6},  // R6
        {4'd7, 2'd0,8'h00,8'h00,32'h0,        32'hDEAD3340,8'hDE,4'h7,4'h0,1'b0,1'b0,4'd6},  // R6
        {4'd4, 2'd0,8'h00,8'h00,32'h0,        32'h00003300,8'hDE,4'h7,4'h0,1'b0,1'b0,4'd6},  // R6
        {4'd5, 2'd2,8'h00,8'h00,32'h0,        32'h00003300,8'h77,4'h7,4'h0,1'b0,1'b0,4'd6},  // R6
        {4'd13,2'd0,8'h00,8'h03,32'h0,        32'h00003300,8'h77,4'h7,4'h3,1'b0,1'b0,4'd8},  // R8
        {4'd12,2'd0,8'h00,8'h02,32'h0,        32'h00003300,8'h77,4'h7,4'h1,1'b0,1'b0,4'd8},  // R8
        {4'd4, 2'd0,8'h00,8'h00,32'h0,        32'h00003320,8'h77,4'h7,4'h1,1'b0,1'b0,4'd8},  // R8
        {4'd12,2'd0,8'h00,8'h01,32'h0,        32'h00003320,8'h77,4'h7,4'h0,1'b0,1'b0,4'd8},  // R8
        {4'd4, 2'd0,8'h00,8'h00,32'h0,        32'h00003300,8'h77,4'h7,4'h0,1'b0,1'b0,4'd8},  // R8
        {4'd8, 2'd0,8'h00,8'h00,32'h0,        32'h00003300,8'h77,4'h7,4'h0,1'b0,1'b1,4'd7},  // R7
        {4'd9, 2'd0,8'h00,8'h00,32'h0,        32'h00003300,8'h77,4'h7,4'h0,1'b0,1'b0,4'd7},  // R7
        {4'd11,2'd0,8'h00,8'h00,32'h0,        32'h00003300,8'h77,4'h7,4'h0,1'b0,1'b0,4'd7},  // R7
        {4'd0, 2'd0,8'hFF,8'hFF,32'hFFFFFFFF, 32'h00003300,8'h77,4'h7,4'h0,1'b0,1'b0,4'd11}, // R11
        {4'd14,2'd0,8'h00,8'h00,32'h0,        32'h00003300,8'h77,4'h9,4'h0,1'b0,1'b0,4'd9}   // R9
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [31:0] e_pair, input logic [7:0] e_acc,
                             input logic [3:0] e_flg, input logic [3:0] e_ier,
                             input logic e_lw, input logic e_lk);
        check(req, "pair_rd",   pair_rd,           e_pair);
        check(req, "acc_rd",    {24'h0, acc_rd},   {24'h0, e_acc});
        check(req, "flags",     {28'h0, flags},    {28'h0, e_flg});
        check(req, "int_en",    {28'h0, int_en},   {28'h0, e_ier});
        check(req, "long_word", {31'h0, long_word}, {31'h0, e_lw});
        check(req, "bus_lock",  {31'h0, bus_lock},  {31'h0, e_lk});
    endtask

    task automatic do_op(input logic v, input logic [3:0] op, input logic [1:0] g,
                         input logic [7:0] a, input logic [7:0] i, input logic [31:0] p);
        @(negedge clk);
        op_valid = v; op_sel = op; grp_sel = g; acc_in = a; imm_in = i; pair_in = p;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_all("R1", 32'h0, 8'h0, 4'h0, 4'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            logic [107:0] r;
            string req;
            r = VEC[k];
            do_op(1'b1, r[107:104], r[103:102], r[101:94], r[93:86], r[85:54]);
            req = $sformatf("R%0d", r[3:0]);
            check_all(req, r[53:22], r[21:14], r[13:10], r[9:6], r[5], r[4]);
        end

        // R11: strobe low, lock-set and broadcast presented, then read back
        do_op(1'b0, 4'd8, 2'd0, 8'h00, 8'h00, 32'h0);
        check("R11", "bus_lock idle", {31'h0, bus_lock}, 32'h0);
        do_op(1'b0, 4'd1, 2'd0, 8'hFF, 8'h00, 32'h0);
        do_op(1'b0, 4'd13, 2'd0, 8'h00, 8'h0F, 32'h0);
        do_op(1'b1, 4'd4, 2'd0, 8'h00, 8'h00, 32'h0);
        check("R11", "pair_rd idle", pair_rd, 32'h00003300);
        check("R11", "int_en idle", {28'h0, int_en}, 32'h0);

        // R1: reset in mid-run clears everything
        do_op(1'b1, 4'd13, 2'd0, 8'h00, 8'h0F, 32'h0);
        check("R8", "int_en all", {28'h0, int_en}, 32'hF);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_all("R1", 32'h0, 8'h0, 4'h0, 4'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        do_op(1'b1, 4'd4, 2'd0, 8'h00, 8'h00, 32'h0);
        check("R1", "status after reset", pair_rd, 32'h0);

        finish_run();
    end
endmodule